// File: doc/BRIEF.md
# Scoreboard In-Order Issue Controller

This block sits at the decode/issue boundary of a pipeline whose functional units finish in an order that can differ from program order. It holds one candidate instruction per cycle. The candidate has an operation class, an optional destination register and two source registers. The block decides whether the candidate can leave for a functional unit in this cycle. A pending-write bit per general register marks registers whose value in the register file is stale because an earlier instruction will still overwrite it.

The upstream stage keeps the candidate stable while `in_ready` is low. Issue therefore happens strictly in program order, and a held instruction holds back every younger one. Each class has a fixed number of in-flight slots. Completion ports return results in any order. Each completion writes its result into the local register file, clears the pending bit of its register and releases a slot of its class. Source operands for the candidate are read from the register file, with results that arrive in the same cycle forwarded.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset every pending bit is clear, every register reads zero, and every class has all of its slots free.
- R2: A valid candidate whose source A or source B register has its pending bit set is not issued. In that case `stall_raw` is high and `in_ready` is low. A pending bit that a completion clears in the same cycle does not count as set.
- R3: A valid candidate with `in_has_dst`=1 and a pending destination register is not issued, and `stall_waw` is high.
- R4: `issue_fire` equals `in_valid` AND `in_ready`. An issue with `in_has_dst`=1 and a nonzero destination sets that register's pending bit from the next cycle on.
- R5: Each class 0..NCLS-1 allows SLOTS instructions in flight. A class index at or above NCLS counts as full. A valid candidate whose class is full raises `stall_full` and is not issued. A completion tagged with a class releases one slot, and that slot can be used in the same cycle.
- R6: A completion with `cmp_has_dst`=1 writes its data into its register and clears that register's pending bit from the next cycle on. Completions may come in any order and on any port.
- R7: When a completion clears a pending bit in the same cycle that the candidate checks it, the candidate can issue in that cycle. Its operand output then carries the completing data.
- R8: When a completion clears and an issue sets the same register's pending bit in one cycle, the bit is set afterwards.
- R9: Register 0 is never marked pending, always reads zero, and ignores completion writes. An issue with `in_has_dst`=0 sets no pending bit.
- R10: `op_a` and `op_b` carry the current values of the source A and source B registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Candidate instruction present |
| in_cls | input | CLS_W | Functional unit class of the candidate |
| in_has_dst | input | 1 | Candidate writes a destination register |
| in_dst | input | AW | Destination register index |
| in_src_a | input | AW | Source A register index |
| in_src_b | input | AW | Source B register index |
| in_ready | output | 1 | No hazard holds the candidate |
| issue_fire | output | 1 | Candidate leaves for its functional unit this cycle |
| stall_raw | output | 1 | Held by a pending source |
| stall_waw | output | 1 | Held by a pending destination |
| stall_full | output | 1 | Held by a full functional unit class |
| op_a | output | DW | Source A operand value |
| op_b | output | DW | Source B operand value |
| cmp_valid | input | NCMP | Completion present, one bit per port |
| cmp_cls | input | NCMP*CLS_W | Class of each completion |
| cmp_has_dst | input | NCMP | Completion carries a register result |
| cmp_dst | input | NCMP*AW | Register written by each completion |
| cmp_data | input | NCMP*DW | Result data of each completion |
| pend_bits | output | NREG | Pending-write bit per register |
| rd_addr | input | AW | Observation read index |
| rd_data | output | DW | Observation read value |

## Verification
The checker watches four rules in every cycle. A destination that issues becomes pending on the next cycle. Register 0 never becomes pending. With no completion arriving, a pending source or destination always blocks issue. A completed register loses its pending bit unless the same cycle re-marks it. The bench scenarios show the rest: out-of-order completions across both ports, data forwarding and slot release within the same cycle, class exhaustion, instructions without a destination, and the register values that come back through the read port.

// File: rtl/sb_issue_pkg.sv
package sb_issue_pkg;

   // Reasons a candidate is held at issue.
   typedef struct packed {
      logic raw;
      logic waw;
      logic full;
   } sb_hold_t;

   // Bits needed to hold values 0..max_val.
   function automatic int unsigned sb_cnt_w(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

   // Bits needed to index n items (at least one).
   function automatic int unsigned sb_idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sb_pend_array.sv
module sb_pend_array #(
   parameter int NREG = 8,
   parameter int AW   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_en,
   input  logic [AW-1:0]   set_idx,
   input  logic [NREG-1:0] clr_vec,
   output logic [NREG-1:0] pend_q,
   output logic [NREG-1:0] pend_view
);

   logic [NREG-1:0] set_vec;

   // Register 0 never receives a set.
   always_comb begin
      set_vec = '0;
      for (int i = 1; i < NREG; i++) begin
         if (set_en && (set_idx == AW'(i))) set_vec[i] = 1'b1;
      end
   end

   // What the issue check sees: clears of this cycle already applied.
   assign pend_view = pend_q & ~clr_vec;

   // A set in the same cycle overrides a clear.
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

endmodule

// File: rtl/sb_slot_track.sv
module sb_slot_track #(
   parameter int NCLS  = 3,
   parameter int SLOTS = 2,
   parameter int NCMP  = 2,
   parameter int CLS_W = 2,
   parameter int CNT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_en,
   input  logic [CLS_W-1:0]  issue_cls,
   input  logic [NCMP-1:0]   cmp_valid,
   input  logic [NCMP*CLS_W-1:0] cmp_cls,
   output logic [NCLS-1:0]   cls_full
);

   for (genvar c = 0; c < NCLS; c++) begin : g_cls
      logic [CNT_W-1:0] busy_q;
      logic [CNT_W-1:0] frees;
      logic [CNT_W-1:0] left;
      logic             take;

      always_comb begin
         frees = '0;
         for (int p = 0; p < NCMP; p++) begin
            if (cmp_valid[p] && (cmp_cls[p*CLS_W +: CLS_W] == CLS_W'(c)))
               frees = frees + CNT_W'(1);
         end
      end

      // Slots released this cycle are usable this cycle.
      assign left        = (frees > busy_q) ? '0 : (busy_q - frees);
      assign cls_full[c] = (left >= CNT_W'(SLOTS));
      assign take        = issue_en && (issue_cls == CLS_W'(c));

      always_ff @(posedge clk) begin
         if (!rst_n) busy_q <= '0;
         else        busy_q <= left + CNT_W'(take);
      end
   end

endmodule

// File: rtl/sb_regfile.sv
module sb_regfile #(
   parameter int NREG = 8,
   parameter int DW   = 16,
   parameter int AW   = 3,
   parameter int NCMP = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NCMP-1:0]    wr_en,
   input  logic [NCMP*AW-1:0] wr_idx,
   input  logic [NCMP*DW-1:0] wr_data,
   input  logic [AW-1:0]      ra_idx,
   input  logic [AW-1:0]      rb_idx,
   input  logic [AW-1:0]      rc_idx,
   output logic [DW-1:0]      ra_data,
   output logic [DW-1:0]      rb_data,
   output logic [DW-1:0]      rc_data
);

   logic [NREG*DW-1:0] flat;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      if (r == 0) begin : g_zero
         assign flat[DW-1:0] = '0;
      end else begin : g_store
         logic [DW-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else begin
               // Higher port takes precedence on a collision.
               for (int p = 0; p < NCMP; p++) begin
                  if (wr_en[p] && (wr_idx[p*AW +: AW] == AW'(r)))
                     q <= wr_data[p*DW +: DW];
               end
            end
         end
         assign flat[r*DW +: DW] = q;
      end
   end

   function automatic logic [DW-1:0] pick(input logic [AW-1:0] idx);
      logic [DW-1:0] v;
      v = '0;
      for (int i = 0; i < NREG; i++) begin
         if (idx == AW'(i)) v = flat[i*DW +: DW];
      end
      return v;
   endfunction

   assign ra_data = pick(ra_idx);
   assign rb_data = pick(rb_idx);
   assign rc_data = pick(rc_idx);

endmodule

// File: rtl/sb_hazard_chk.sv
module sb_hazard_chk
   import sb_issue_pkg::*;
#(
   parameter int NREG = 8,
   parameter int AW   = 3
) (
   input  logic            in_valid,
   input  logic            in_has_dst,
   input  logic [AW-1:0]   in_dst,
   input  logic [AW-1:0]   in_src_a,
   input  logic [AW-1:0]   in_src_b,
   input  logic            cls_full,
   input  logic [NREG-1:0] pend_view,
   output sb_hold_t        hold,
   output logic            ready,
   output logic            fire
);

   function automatic logic busy(input logic [AW-1:0] idx);
      logic b;
      b = 1'b0;
      for (int i = 0; i < NREG; i++) begin
         if (idx == AW'(i)) b = pend_view[i];
      end
      return b;
   endfunction

   always_comb begin
      hold.raw  = busy(in_src_a) | busy(in_src_b);
      hold.waw  = in_has_dst & (in_dst != '0) & busy(in_dst);
      hold.full = cls_full;
   end

   assign ready = ~(hold.raw | hold.waw | hold.full);
   assign fire  = in_valid & ready;

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
   import sb_issue_pkg::*;
#(
   parameter int NREG  = 8,
   parameter int DW    = 16,
   parameter int NCLS  = 3,
   parameter int SLOTS = 2,
   parameter int NCMP  = 2,
   parameter int AW    = sb_idx_w(NREG),
   parameter int CLS_W = sb_idx_w(NCLS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [CLS_W-1:0]      in_cls,
   input  logic                  in_has_dst,
   input  logic [AW-1:0]         in_dst,
   input  logic [AW-1:0]         in_src_a,
   input  logic [AW-1:0]         in_src_b,
   output logic                  in_ready,
   output logic                  issue_fire,
   output logic                  stall_raw,
   output logic                  stall_waw,
   output logic                  stall_full,
   output logic [DW-1:0]         op_a,
   output logic [DW-1:0]         op_b,
   input  logic [NCMP-1:0]       cmp_valid,
   input  logic [NCMP*CLS_W-1:0] cmp_cls,
   input  logic [NCMP-1:0]       cmp_has_dst,
   input  logic [NCMP*AW-1:0]    cmp_dst,
   input  logic [NCMP*DW-1:0]    cmp_data,
   output logic [NREG-1:0]       pend_bits,
   input  logic [AW-1:0]         rd_addr,
   output logic [DW-1:0]         rd_data
);

   localparam int CNT_W    = sb_cnt_w(SLOTS);
   localparam int CLS_SPAN = 1 << CLS_W;

   initial begin
      assert (NREG >= 2 && (1 << AW) >= NREG) else $error("sb_issue_ctrl: bad NREG/AW");
      assert (NCLS >= 1 && CLS_SPAN >= NCLS) else $error("sb_issue_ctrl: bad NCLS/CLS_W");
      assert (SLOTS >= 1)                     else $error("sb_issue_ctrl: SLOTS must be positive");
      assert (NCMP >= 1)                      else $error("sb_issue_ctrl: NCMP must be positive");
      assert (DW >= 1)                        else $error("sb_issue_ctrl: DW must be positive");
   end

   logic [NREG-1:0]     clr_vec;
   logic [NREG-1:0]     pend_view;
   logic [NCMP-1:0]     wr_en;
   logic [NCLS-1:0]     cls_full;
   logic [CLS_SPAN-1:0] full_pad;
   logic                sel_full;
   logic                set_en;
   logic [DW-1:0]       rf_a;
   logic [DW-1:0]       rf_b;
   sb_hold_t            hold;

   // Completion decode: write enables and the clear mask.
   for (genvar p = 0; p < NCMP; p++) begin : g_cmp
      assign wr_en[p] = cmp_valid[p] & cmp_has_dst[p];
   end

   always_comb begin
      clr_vec = '0;
      for (int p = 0; p < NCMP; p++) begin
         for (int r = 1; r < NREG; r++) begin
            if (wr_en[p] && (cmp_dst[p*AW +: AW] == AW'(r))) clr_vec[r] = 1'b1;
         end
      end
   end

   // Classes beyond NCLS look permanently full.
   always_comb begin
      full_pad = '1;
      for (int c = 0; c < NCLS; c++) full_pad[c] = cls_full[c];
   end
   assign sel_full = full_pad[in_cls];

   sb_hazard_chk #(.NREG(NREG), .AW(AW)) u_hazard (
      .in_valid   (in_valid),
      .in_has_dst (in_has_dst),
      .in_dst     (in_dst),
      .in_src_a   (in_src_a),
      .in_src_b   (in_src_b),
      .cls_full   (sel_full),
      .pend_view  (pend_view),
      .hold       (hold),
      .ready      (in_ready),
      .fire       (issue_fire)
   );

   assign stall_raw  = in_valid & hold.raw;
   assign stall_waw  = in_valid & hold.waw;
   assign stall_full = in_valid & hold.full;
   assign set_en     = issue_fire & in_has_dst;

   sb_pend_array #(.NREG(NREG), .AW(AW)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (set_en),
      .set_idx   (in_dst),
      .clr_vec   (clr_vec),
      .pend_q    (pend_bits),
      .pend_view (pend_view)
   );

   sb_slot_track #(
      .NCLS(NCLS), .SLOTS(SLOTS), .NCMP(NCMP), .CLS_W(CLS_W), .CNT_W(CNT_W)
   ) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_en  (issue_fire),
      .issue_cls (in_cls),
      .cmp_valid (cmp_valid),
      .cmp_cls   (cmp_cls),
      .cls_full  (cls_full)
   );

   sb_regfile #(.NREG(NREG), .DW(DW), .AW(AW), .NCMP(NCMP)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (cmp_dst),
      .wr_data (cmp_data),
      .ra_idx  (in_src_a),
      .rb_idx  (in_src_b),
      .rc_idx  (rd_addr),
      .ra_data (rf_a),
      .rb_data (rf_b),
      .rc_data (rd_data)
   );

   // Operand forwarding from completions arriving this cycle.
   always_comb begin
      op_a = rf_a;
      op_b = rf_b;
      for (int p = 0; p < NCMP; p++) begin
         if (wr_en[p] && (cmp_dst[p*AW +: AW] != '0)) begin
            if (cmp_dst[p*AW +: AW] == in_src_a) op_a = cmp_data[p*DW +: DW];
            if (cmp_dst[p*AW +: AW] == in_src_b) op_b = cmp_data[p*DW +: DW];
         end
      end
   end

endmodule

// File: rtl/sb_issue_ctrl_chk.sv
module sb_issue_ctrl_chk #(
   parameter int NREG  = 8,
   parameter int NCMP  = 2,
   parameter int AW    = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_has_dst,
   input logic [AW-1:0]      in_dst,
   input logic [AW-1:0]      in_src_a,
   input logic [AW-1:0]      in_src_b,
   input logic               in_ready,
   input logic               issue_fire,
   input logic [NCMP-1:0]    cmp_valid,
   input logic [NCMP-1:0]    cmp_has_dst,
   input logic [NCMP*AW-1:0] cmp_dst,
   input logic [NREG-1:0]    pend_bits
);

   logic [AW-1:0] c0_dst;
   logic          c0_clr;
   logic          reissue0;
   assign c0_dst   = cmp_dst[AW-1:0];
   assign c0_clr   = cmp_valid[0] & cmp_has_dst[0] & (c0_dst != '0);
   assign reissue0 = issue_fire & in_has_dst & (in_dst == c0_dst);

   AST_FIRE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      issue_fire |-> (in_valid && in_ready)) else $error("fire without ready"); // R4

   AST_ISSUE_MARKS_DST: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_fire && in_has_dst && in_dst != '0) |=> pend_bits[$past(in_dst)])
      else $error("issued destination not pending"); // R4

   AST_ZERO_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_bits[0]) else $error("register 0 pending"); // R9

   AST_RAW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cmp_valid == '0 && (pend_bits[in_src_a] || pend_bits[in_src_b]))
      |-> !issue_fire) else $error("issue over pending source"); // R2

   AST_WAW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cmp_valid == '0 && in_has_dst && pend_bits[in_dst])
      |-> !issue_fire) else $error("issue over pending destination"); // R3

   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (c0_clr && !reissue0) |=> !pend_bits[$past(c0_dst)])
      else $error("completed register still pending"); // R6

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (c0_clr && reissue0) |=> pend_bits[$past(c0_dst)])
      else $error("clear overrode set"); // R8

endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk #(.NREG(NREG), .NCMP(NCMP), .AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_has_dst  (in_has_dst),
   .in_dst      (in_dst),
   .in_src_a    (in_src_a),
   .in_src_b    (in_src_b),
   .in_ready    (in_ready),
   .issue_fire  (issue_fire),
   .cmp_valid   (cmp_valid),
   .cmp_has_dst (cmp_has_dst),
   .cmp_dst     (cmp_dst),
   .pend_bits   (pend_bits)
);

// File: tb/sb_issue_ctrl_test.sv
`timescale 1ns/100ps
module sb_issue_ctrl_test;

   localparam int NREG = 8, DW = 16, NCLS = 3, SLOTS = 2, NCMP = 2, AW = 3, CW = 2;

   typedef struct packed {
      logic        v;
      logic [1:0]  cls;
      logic        hd;
      logic [2:0]  dst, sa, sb;
      logic        cv;
      logic [1:0]  ccls;
      logic        chd;
      logic [2:0]  cdst;
      logic [15:0] cdat;
      logic        efire;
      logic [7:0]  epend;
      logic [15:0] eopa, eopb;
   } vec_t;

   function automatic vec_t mk(input int v, cls, hd, dst, sa, sb,
                               input int cv, ccls, chd, cdst, cdat,
                               input int efire, epend, eopa, eopb);
      vec_t t;
      t.v = 1'(v); t.cls = 2'(cls); t.hd = 1'(hd);
      t.dst = 3'(dst); t.sa = 3'(sa); t.sb = 3'(sb);
      t.cv = 1'(cv); t.ccls = 2'(ccls); t.chd = 1'(chd);
      t.cdst = 3'(cdst); t.cdat = 16'(cdat);
      t.efire = 1'(efire); t.epend = 8'(epend);
      t.eopa = 16'(eopa); t.eopb = 16'(eopb);
      return t;
   endfunction

   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      mk(1,0,1,1,2,3, 0,0,0,0,0,      1,'h02,0,0),
      mk(1,1,1,2,1,0, 0,0,0,0,0,      0,'h02,0,0),
      mk(1,1,1,2,1,0, 1,0,1,1,'h1111, 1,'h04,'h1111,0),
      mk(1,0,1,2,3,4, 0,0,0,0,0,      0,'h04,0,0),
      mk(1,0,1,3,1,1, 0,0,0,0,0,      1,'h0C,'h1111,'h1111),
      mk(1,0,1,4,0,0, 0,0,0,0,0,      1,'h1C,0,0),
      mk(1,0,1,5,0,0, 0,0,0,0,0,      0,'h1C,0,0),
      mk(1,0,1,5,0,0, 1,0,1,4,'h4444, 1,'h2C,0,0),
      mk(0,0,0,0,0,0, 1,1,1,2,'h2222, 0,'h28,0,0),
      mk(1,2,0,6,2,4, 0,0,0,0,0,      1,'h28,'h2222,'h4444),
      mk(1,2,1,0,4,4, 0,0,0,0,0,      1,'h28,'h4444,'h4444)
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic               in_valid, in_has_dst;
   logic [CW-1:0]      in_cls;
   logic [AW-1:0]      in_dst, in_src_a, in_src_b;
   logic               in_ready, issue_fire, stall_raw, stall_waw, stall_full;
   logic [DW-1:0]      op_a, op_b;
   logic [NCMP-1:0]    cmp_valid, cmp_has_dst;
   logic [NCMP*CW-1:0] cmp_cls;
   logic [NCMP*AW-1:0] cmp_dst;
   logic [NCMP*DW-1:0] cmp_data;
   logic [NREG-1:0]    pend_bits;
   logic [AW-1:0]      rd_addr;
   logic [DW-1:0]      rd_data;

   sb_issue_ctrl #(.NREG(NREG), .DW(DW), .NCLS(NCLS), .SLOTS(SLOTS), .NCMP(NCMP)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_cls(in_cls), .in_has_dst(in_has_dst),
      .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .in_ready(in_ready), .issue_fire(issue_fire),
      .stall_raw(stall_raw), .stall_waw(stall_waw), .stall_full(stall_full),
      .op_a(op_a), .op_b(op_b),
      .cmp_valid(cmp_valid), .cmp_cls(cmp_cls), .cmp_has_dst(cmp_has_dst),
      .cmp_dst(cmp_dst), .cmp_data(cmp_data),
      .pend_bits(pend_bits), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic idle();
      in_valid = 0; in_cls = '0; in_has_dst = 0;
      in_dst = '0; in_src_a = '0; in_src_b = '0;
      cmp_valid = '0; cmp_cls = '0; cmp_has_dst = '0; cmp_dst = '0; cmp_data = '0;
      rd_addr = '0;
   endtask

   task automatic put_issue(input int cls, input int hd, input int dst, input int a, input int b);
      in_valid = 1; in_cls = CW'(cls); in_has_dst = 1'(hd);
      in_dst = AW'(dst); in_src_a = AW'(a); in_src_b = AW'(b);
   endtask

   task automatic put_done(input int p, input int cls, input int dst, input logic [15:0] d);
      cmp_valid[p] = 1'b1; cmp_has_dst[p] = 1'b1;
      cmp_cls[p*CW +: CW] = CW'(cls);
      cmp_dst[p*AW +: AW] = AW'(dst);
      cmp_data[p*DW +: DW] = d;
   endtask

   task automatic edge_then_sample();
      @(posedge clk); #1;
   endtask

   initial begin
      #(4 * 20000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      #1;
      chk("R1 pending after reset", 32'(pend_bits), 32'h0);
      chk("R1 ready after reset", 32'(in_ready), 32'h1);
      chk("R1 no fire when idle", 32'(issue_fire), 32'h0);
      @(negedge clk); rst_n = 1;
      for (int r = 0; r < NREG; r++) begin
         @(negedge clk); rd_addr = AW'(r); #1;
         chk($sformatf("R1 reg%0d after reset", r), 32'(rd_data), 32'h0);
      end

      // Vector walk: issue, hold, forward, slot reuse, no-destination cases.
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         idle();
         in_valid = TBL[i].v; in_cls = TBL[i].cls; in_has_dst = TBL[i].hd;
         in_dst = TBL[i].dst; in_src_a = TBL[i].sa; in_src_b = TBL[i].sb;
         if (TBL[i].cv) put_done(0, TBL[i].ccls, TBL[i].cdst, TBL[i].cdat);
         #1;
         chk($sformatf("R4 R2 R3 R5 R7 fire vec%0d", i), 32'(issue_fire), 32'(TBL[i].efire));
         chk($sformatf("R10 R7 op_a vec%0d", i), 32'(op_a), 32'(TBL[i].eopa));
         chk($sformatf("R10 op_b vec%0d", i), 32'(op_b), 32'(TBL[i].eopb));
         edge_then_sample();
         chk($sformatf("R4 R6 R8 R9 pending vec%0d", i), 32'(pend_bits), 32'(TBL[i].epend));
      end

      // R6: completions out of order, across both ports.
      @(negedge clk); idle(); put_done(1, 0, 5, 16'h5555);
      edge_then_sample();
      chk("R6 port1 clears r5 first", 32'(pend_bits), 32'h08);
      @(negedge clk); idle(); put_done(0, 0, 3, 16'h3333);
      edge_then_sample();
      chk("R6 port0 clears r3 later", 32'(pend_bits), 32'h00);
      @(negedge clk); idle(); rd_addr = 3'd5; #1;
      chk("R6 r5 data", 32'(rd_data), 32'h5555);
      @(negedge clk); rd_addr = 3'd3; #1;
      chk("R6 r3 data", 32'(rd_data), 32'h3333);

      // R8: reissue to r3 in the cycle its earlier writer completes.
      @(negedge clk); idle(); put_issue(0, 1, 3, 0, 0); #1;
      chk("R4 issue to r3", 32'(issue_fire), 32'h1);
      edge_then_sample();
      chk("R4 r3 pending", 32'(pend_bits), 32'h08);
      @(negedge clk); idle(); put_issue(0, 1, 3, 0, 0); put_done(0, 0, 3, 16'hAAAA); #1;
      chk("R7 clear visible to waw check", 32'(issue_fire), 32'h1);
      edge_then_sample();
      chk("R8 set wins over clear", 32'(pend_bits), 32'h08);
      @(negedge clk); idle(); rd_addr = 3'd3; #1;
      chk("R6 r3 rewritten", 32'(rd_data), 32'hAAAA);

      // R2 / R3: hold flags with r3 pending.
      @(negedge clk); idle(); put_issue(1, 1, 4, 3, 0); #1;
      chk("R2 raw flag", 32'(stall_raw), 32'h1);
      chk("R2 ready low", 32'(in_ready), 32'h0);
      chk("R2 no fire", 32'(issue_fire), 32'h0);
      @(negedge clk); idle(); put_issue(1, 1, 3, 0, 0); #1;
      chk("R3 waw flag", 32'(stall_waw), 32'h1);
      chk("R3 no fire", 32'(issue_fire), 32'h0);
      edge_then_sample();
      chk("R3 pending unchanged", 32'(pend_bits), 32'h08);

      // R9: completion to register 0 is dropped; it still frees a class 2 slot.
      @(negedge clk); idle(); put_done(0, 2, 0, 16'hBEEF);
      edge_then_sample();
      @(negedge clk); idle(); rd_addr = 3'd0; #1;
      chk("R9 r0 reads zero", 32'(rd_data), 32'h0);
      chk("R9 r0 not pending", 32'(pend_bits), 32'h08);

      // R5: class 2 has one free slot, then none.
      @(negedge clk); idle(); put_issue(2, 0, 0, 0, 0); #1;
      chk("R5 last slot used", 32'(issue_fire), 32'h1);
      edge_then_sample();
      @(negedge clk); idle(); put_issue(2, 0, 0, 0, 0); #1;
      chk("R5 full flag", 32'(stall_full), 32'h1);
      chk("R5 no fire when full", 32'(issue_fire), 32'h0);
      @(negedge clk); idle(); put_issue(3, 0, 0, 0, 0); #1;
      chk("R5 class out of range is full", 32'(stall_full), 32'h1);

      // R1: reset in mid-run.
      @(negedge clk); idle(); rst_n = 0;
      edge_then_sample();
      chk("R1 pending cleared by reset", 32'(pend_bits), 32'h0);
      @(negedge clk); rd_addr = 3'd3; #1;
      chk("R1 r3 cleared by reset", 32'(rd_data), 32'h0);
      @(negedge clk); rst_n = 1;
      @(negedge clk); idle(); put_issue(2, 0, 0, 0, 0); #1;
      chk("R1 slots freed by reset", 32'(issue_fire), 32'h1);
      @(negedge clk); idle();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule